// File: doc/BRIEF.md
# Memory Card SPI Start-Up Sequencer

This block takes a removable memory card from power-up into its SPI operating mode and works out which generation of card is attached. It does not shift bits itself. It drives a neighbouring command engine one command at a time. For each command it presents an index, a 32-bit argument and a CRC byte. The engine then returns a status byte, or flags a timeout. The sequencer also asks a byte shifter for a burst of idle bytes, forces the chip select high during that burst, and chooses between a slow start-up clock and a fast transfer clock.

After a start pulse the sequencer walks a fixed command order:
- a software reset;
- an interface condition probe whose reply splits the flow into two retry loops;
- the operating-condition handshake, repeated until the card reports ready;
- a block-length setting.

On success it reports the card class and the address multiplier the data path must apply: bytes for the older cards, blocks for high-capacity ones. On any failure it raises an error flag. In both cases it returns to an idle state that waits for the next start pulse.

Top module: `card_init_seq`

## Requirements
- R1: After a start pulse, and before any command, the block issues exactly one idle-byte burst request. The burst length output reads PRE_BYTES (16 by default), chip select is forced high and the slow clock is selected. No command request ever coincides with the forced chip select.
- R2: The first command is index 0 with argument 0x00000000 and CRC byte 0x95. Only a status of exactly 0x01 lets the sequence continue; any other status ends the run in error.
- R3: The second command is index 8 with argument 0x000001AA and CRC byte 0x87. Status 0x01 enters the high-capacity loop, status 0x05 enters the legacy loop, and any other status is an error.
- R4: Legacy loop: each attempt is index 55 (argument 0), then index 41 (argument 0). It repeats until index 41 returns 0x00. If MAX_TRIES attempts all fail, the run ends in error.
- R5: High-capacity loop: each attempt is index 58 (argument 0), then index 55 (argument 0), then index 41 (argument 0x40000000). One more index 58 follows success. If MAX_TRIES attempts fail, the run ends in error.
- R6: Before every high-capacity attempt the block pauses. The index 58 request appears exactly RETRY_DELAY+2 cycles after the cycle in which the preceding done pulse was high. Every other request appears in the cycle right after the preceding done.
- R7: The last command is index 16 with argument 512. Status 0x00 sets init_done and selects the fast clock (clk_fast=1). Any other status sets init_error and keeps the slow clock.
- R8: card_type encodes the result: 0 = none/failed, 1 = legacy, 3 = high capacity (2 is never produced). addr_mult is 512 for legacy, 1 for high capacity, and 0 after an error.
- R9: A command-engine timeout on any command whose status is checked (indices 0, 8, 41, 16) counts as a failing status. The statuses of indices 55 and 58 are ignored.
- R10: cmd_req is a single-cycle pulse, and index, argument and CRC stay stable until cmd_done. Commands other than indices 0 and 8 carry CRC byte 0xFF. After success or error no further request is made until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| cmd_req | output | 1 | One-cycle command request to the engine |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | CRC/end byte sent with the command |
| cmd_done | input | 1 | Engine finished the command (one cycle) |
| cmd_status | input | 8 | Status byte returned by the card |
| cmd_timeout | input | 1 | Engine saw no reply |
| cs_force_high | output | 1 | Holds chip select high during the idle burst |
| dummy_req | output | 1 | One-cycle request for an idle-byte burst |
| dummy_len | output | 8 | Number of idle bytes in the burst |
| dummy_done | input | 1 | Burst finished (one cycle) |
| clk_fast | output | 1 | 1 selects the fast transfer clock |
| init_done | output | 1 | Start-up finished successfully |
| init_error | output | 1 | Start-up failed |
| card_type | output | 2 | Card class code |
| addr_mult | output | 10 | Address multiplier for the data path |

## Verification
The bench builds the block with MAX_TRIES=4 and RETRY_DELAY=3 in place of the real-time defaults. With these values, running out of retries in both loops takes only a few dozen commands. The pause before each high-capacity attempt can then be measured to the exact cycle. A responder in the bench replies to each command from a per-run scenario: chosen status values, a number of "not ready" replies, and a timeout on one chosen index. This covers both classification paths, every error exit and the ignored statuses.

// File: rtl/card_init_pkg.sv
package card_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_RESET,
        ST_PROBE,
        ST_V1_APP,
        ST_V1_OP,
        ST_V2_WAIT,
        ST_V2_OCR,
        ST_V2_APP,
        ST_V2_OP,
        ST_V2_OCRF,
        ST_BLKLEN
    } seq_state_e;

    typedef enum logic [1:0] {
        CARD_NONE = 2'd0,
        CARD_V1   = 2'd1,
        CARD_V2   = 2'd2,
        CARD_V2HC = 2'd3
    } card_kind_e;

    localparam logic [5:0]  IDX_RESET  = 6'd0;
    localparam logic [5:0]  IDX_PROBE  = 6'd8;
    localparam logic [5:0]  IDX_BLKLEN = 6'd16;
    localparam logic [5:0]  IDX_OPCOND = 6'd41;
    localparam logic [5:0]  IDX_APP    = 6'd55;
    localparam logic [5:0]  IDX_OCR    = 6'd58;

    localparam logic [31:0] ARG_PROBE  = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS    = 32'h4000_0000;
    localparam logic [31:0] ARG_BLK512 = 32'd512;

    localparam logic [7:0]  CRC_RESET  = 8'h95;
    localparam logic [7:0]  CRC_PROBE  = 8'h87;
    localparam logic [7:0]  CRC_NONE   = 8'hFF;

    localparam logic [7:0]  ST_IDLE_BIT  = 8'h01;
    localparam logic [7:0]  ST_IDLE_ILL  = 8'h05;
    localparam logic [7:0]  ST_READY     = 8'h00;

    function automatic logic is_cmd_state(seq_state_e s);
        return (s != ST_IDLE) && (s != ST_PRE) && (s != ST_V2_WAIT);
    endfunction

endpackage

// File: rtl/card_init_retry.sv
module card_init_retry #(
    parameter int MAX_TRIES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The attempt under way is the final one allowed
    assign last = (cnt_q == CW'(MAX_TRIES - 1));

endmodule

// File: rtl/card_init_delay.sv
module card_init_delay #(
    parameter int DELAY = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int DW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = DW'(DELAY);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0) && !load;

endmodule

// File: rtl/card_init_seq.sv
module card_init_seq
    import card_init_pkg::*;
#(
    parameter int MAX_TRIES   = 5000,
    parameter int RETRY_DELAY = 5_000_000,
    parameter int PRE_BYTES   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        cmd_req,
    output logic [5:0]  cmd_index,
    output logic [31:0] cmd_arg,
    output logic [7:0]  cmd_crc,
    input  logic        cmd_done,
    input  logic [7:0]  cmd_status,
    input  logic        cmd_timeout,
    output logic        cs_force_high,
    output logic        dummy_req,
    output logic [7:0]  dummy_len,
    input  logic        dummy_done,
    output logic        clk_fast,
    output logic        init_done,
    output logic        init_error,
    output logic [1:0]  card_type,
    output logic [9:0]  addr_mult
);
    localparam logic [9:0] MULT_BYTE  = 10'd512;
    localparam logic [9:0] MULT_BLOCK = 10'd1;

    typedef struct packed {
        seq_state_e state;
        logic       issued;
        logic       done;
        logic       err;
        card_kind_e card;
        logic [9:0] mult;
        logic       fast;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic retry_clr, retry_inc, retry_last;
    logic dly_load, dly_expired;

    card_init_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (retry_clr),
        .inc   (retry_inc),
        .last  (retry_last)
    );

    card_init_delay #(.DELAY(RETRY_DELAY)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .expired (dly_expired)
    );

    // Reply qualifiers: a timeout is never a good reply
    logic rsp_idle, rsp_idle_ill, rsp_ready;
    assign rsp_idle     = !cmd_timeout && (cmd_status == ST_IDLE_BIT);
    assign rsp_idle_ill = !cmd_timeout && (cmd_status == ST_IDLE_ILL);
    assign rsp_ready    = !cmd_timeout && (cmd_status == ST_READY);

    always_comb begin
        r_d       = r_q;
        retry_clr = 1'b0;
        retry_inc = 1'b0;
        dly_load  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state  = ST_PRE;
                    r_d.issued = 1'b0;
                    r_d.done   = 1'b0;
                    r_d.err    = 1'b0;
                    r_d.card   = CARD_NONE;
                    r_d.mult   = '0;
                    r_d.fast   = 1'b0;
                    retry_clr  = 1'b1;
                end
            end
            ST_PRE: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (dummy_done) begin
                    r_d.issued = 1'b0;
                    r_d.state  = ST_RESET;
                end
            end
            ST_V2_WAIT: begin
                if (dly_expired) begin
                    r_d.state = ST_V2_OCR;
                end
            end
            default: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (cmd_done) begin
                    r_d.issued = 1'b0;
                    unique case (r_q.state)
                        ST_RESET: begin
                            if (rsp_idle) r_d.state = ST_PROBE;
                            else          r_d.err   = 1'b1;
                        end
                        ST_PROBE: begin
                            if (rsp_idle) begin
                                r_d.state = ST_V2_WAIT;
                                dly_load  = 1'b1;
                            end else if (rsp_idle_ill) begin
                                r_d.state = ST_V1_APP;
                            end else begin
                                r_d.err = 1'b1;
                            end
                        end
                        ST_V1_APP: r_d.state = ST_V1_OP;
                        ST_V1_OP: begin
                            if (rsp_ready) begin
                                r_d.card  = CARD_V1;
                                r_d.mult  = MULT_BYTE;
                                r_d.state = ST_BLKLEN;
                            end else if (retry_last) begin
                                r_d.err = 1'b1;
                            end else begin
                                retry_inc = 1'b1;
                                r_d.state = ST_V1_APP;
                            end
                        end
                        ST_V2_OCR: r_d.state = ST_V2_APP;
                        ST_V2_APP: r_d.state = ST_V2_OP;
                        ST_V2_OP: begin
                            if (rsp_ready) begin
                                r_d.state = ST_V2_OCRF;
                            end else if (retry_last) begin
                                r_d.err = 1'b1;
                            end else begin
                                retry_inc = 1'b1;
                                dly_load  = 1'b1;
                                r_d.state = ST_V2_WAIT;
                            end
                        end
                        ST_V2_OCRF: begin
                            r_d.card  = CARD_V2HC;
                            r_d.mult  = MULT_BLOCK;
                            r_d.state = ST_BLKLEN;
                        end
                        ST_BLKLEN: begin
                            if (rsp_ready) begin
                                r_d.done  = 1'b1;
                                r_d.fast  = 1'b1;
                                r_d.state = ST_IDLE;
                            end else begin
                                r_d.err = 1'b1;
                            end
                        end
                        default: r_d.err = 1'b1;
                    endcase
                    if (r_d.err) begin
                        r_d.state = ST_IDLE;
                        r_d.card  = CARD_NONE;
                        r_d.mult  = '0;
                        r_d.fast  = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, issued: 1'b0, done: 1'b0, err: 1'b0,
                     card: CARD_NONE, mult: '0, fast: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // Command fields follow the registered state only
    always_comb begin
        cmd_index = IDX_RESET;
        cmd_arg   = '0;
        cmd_crc   = CRC_NONE;
        unique case (r_q.state)
            ST_RESET:   begin cmd_index = IDX_RESET;  cmd_crc = CRC_RESET; end
            ST_PROBE:   begin cmd_index = IDX_PROBE;  cmd_arg = ARG_PROBE; cmd_crc = CRC_PROBE; end
            ST_V1_APP,
            ST_V2_APP:  cmd_index = IDX_APP;
            ST_V1_OP:   cmd_index = IDX_OPCOND;
            ST_V2_OP:   begin cmd_index = IDX_OPCOND; cmd_arg = ARG_HCS; end
            ST_V2_OCR,
            ST_V2_OCRF: cmd_index = IDX_OCR;
            ST_BLKLEN:  begin cmd_index = IDX_BLKLEN; cmd_arg = ARG_BLK512; end
            default:    cmd_index = IDX_RESET;
        endcase
    end

    assign cmd_req       = is_cmd_state(r_q.state) && !r_q.issued;
    assign dummy_req     = (r_q.state == ST_PRE) && !r_q.issued;
    assign cs_force_high = (r_q.state == ST_PRE);
    assign dummy_len     = 8'(PRE_BYTES);
    assign clk_fast      = r_q.fast;
    assign init_done     = r_q.done;
    assign init_error    = r_q.err;
    assign card_type     = r_q.card;
    assign addr_mult     = r_q.mult;

endmodule

// File: rtl/card_init_chk.sv
module card_init_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_req,
    input logic [5:0]  cmd_index,
    input logic [31:0] cmd_arg,
    input logic [7:0]  cmd_crc,
    input logic        cs_force_high,
    input logic        dummy_req,
    input logic        clk_fast,
    input logic        init_done,
    input logic        init_error,
    input logic [1:0]  card_type,
    input logic [9:0]  addr_mult
);
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

    p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> ($stable(cmd_index) && $stable(cmd_arg) && $stable(cmd_crc)));

    p_no_cmd_in_burst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> (!cs_force_high && !dummy_req));

    p_burst_slow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_force_high |-> !clk_fast);

    p_fast_only_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fast |-> (init_done && !init_error));

    p_result_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done && init_error));

    p_class_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ((card_type == 2'd1 && addr_mult == 10'd512) ||
                       (card_type == 2'd3 && addr_mult == 10'd1)));

    p_class_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_error |-> (card_type == 2'd0 && addr_mult == 10'd0));

endmodule

bind card_init_seq card_init_chk u_card_init_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_req       (cmd_req),
    .cmd_index     (cmd_index),
    .cmd_arg       (cmd_arg),
    .cmd_crc       (cmd_crc),
    .cs_force_high (cs_force_high),
    .dummy_req     (dummy_req),
    .clk_fast      (clk_fast),
    .init_done     (init_done),
    .init_error    (init_error),
    .card_type     (card_type),
    .addr_mult     (addr_mult)
);

// File: tb/card_init_seq_bench.sv
module card_init_seq_bench;
    localparam int TRIES = 4;
    localparam int DLY   = 3;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_req;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_crc;
    logic        cmd_done = 1'b0;
    logic [7:0]  cmd_status = 8'hFF;
    logic        cmd_timeout = 1'b0;
    logic        cs_force_high;
    logic        dummy_req;
    logic [7:0]  dummy_len;
    logic        dummy_done = 1'b0;
    logic        clk_fast;
    logic        init_done;
    logic        init_error;
    logic [1:0]  card_type;
    logic [9:0]  addr_mult;

    card_init_seq #(.MAX_TRIES(TRIES), .RETRY_DELAY(DLY), .PRE_BYTES(16)) u_card_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
        .cmd_done(cmd_done), .cmd_status(cmd_status), .cmd_timeout(cmd_timeout),
        .cs_force_high(cs_force_high), .dummy_req(dummy_req), .dummy_len(dummy_len),
        .dummy_done(dummy_done), .clk_fast(clk_fast), .init_done(init_done),
        .init_error(init_error), .card_type(card_type), .addr_mult(addr_mult)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Scenario controls
    int s_rst, s_probe, s_fail41, s_blk, s_to, s_ign;
    int n41;

    // Expected command stream
    int          q_idx[$];
    logic [31:0] q_arg[$];
    logic [7:0]  q_crc[$];
    bit          e_done;
    int          e_type;
    int          e_mult;
    int          n_bursts;

    // Request timing model
    bit gap_valid = 1'b0;
    int gap_cyc   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string tag_of(input int idx);
        case (idx)
            0:       return "R2";
            8:       return "R3";
            16:      return "R7";
            58:      return "R5";
            default: return (s_probe == 5) ? "R4" : "R5";
        endcase
    endfunction

    function automatic logic [7:0] reply(input int idx);
        case (idx)
            0:  return 8'(s_rst);
            8:  return 8'(s_probe);
            16: return 8'(s_blk);
            41: begin
                logic [7:0] v;
                v = (s_fail41 < 0 || n41 < s_fail41) ? 8'h01 : 8'h00;
                n41++;
                return v;
            end
            default: return 8'(s_ign);
        endcase
    endfunction

    task automatic push(input int idx, input logic [31:0] a, input logic [7:0] c);
        q_idx.push_back(idx);
        q_arg.push_back(a);
        q_crc.push_back(c);
    endtask

    // Behavioural model of the command order for the current scenario
    task automatic plan();
        bit ok;
        e_done = 1'b0; e_type = 0; e_mult = 0;
        push(0, 32'h0, 8'h95);
        if (s_to == 0 || s_rst != 1) return;
        push(8, 32'h1AA, 8'h87);
        if (s_to == 8 || (s_probe != 1 && s_probe != 5)) return;
        ok = 1'b0;
        for (int a = 0; a < TRIES && !ok; a++) begin
            if (s_probe == 1) push(58, 32'h0, 8'hFF);
            push(55, 32'h0, 8'hFF);
            push(41, (s_probe == 1) ? 32'h4000_0000 : 32'h0, 8'hFF);
            if (s_fail41 >= 0 && a == s_fail41 && s_to != 41) ok = 1'b1;
        end
        if (!ok) return;
        if (s_probe == 1) push(58, 32'h0, 8'hFF);
        push(16, 32'd512, 8'hFF);
        if (s_to == 16 || s_blk != 0) return;
        e_done = 1'b1;
        e_type = (s_probe == 1) ? 3 : 1;
        e_mult = (s_probe == 1) ? 1 : 512;
    endtask

    // Command engine and burst responder
    initial begin : engine
        bit skip;
        skip = 1'b0;
        forever begin
            if (!skip) @(negedge clk);
            skip = 1'b0;
            if (rst_n) begin
                check(!(cmd_req && (cs_force_high || clk_fast)), "R1 no fast clock or forced CS at a request",
                      {cs_force_high, clk_fast}, 0);
                if (dummy_req) begin
                    n_bursts++;
                    gap_valid = 1'b0;
                    check(cs_force_high == 1'b1, "R1 CS forced during burst", cs_force_high, 1);
                    check(dummy_len == 8'd16, "R1 burst length", dummy_len, 16);
                    check(clk_fast == 1'b0, "R1 slow clock during burst", clk_fast, 0);
                    check(q_idx.size() != 0 && q_idx[0] == 0, "R1 burst before any command", q_idx.size(), 1);
                    repeat (3) @(negedge clk);
                    dummy_done = 1'b1;
                    gap_cyc = cyc + 1;
                    gap_valid = 1'b1;
                    @(negedge clk);
                    dummy_done = 1'b0;
                    skip = 1'b1;
                end else if (cmd_req) begin
                    int idx;
                    logic [7:0] st;
                    bit to;
                    logic [5:0] h_idx;
                    logic [31:0] h_arg;
                    logic [7:0] h_crc;
                    idx = int'(cmd_index);
                    h_idx = cmd_index; h_arg = cmd_arg; h_crc = cmd_crc;
                    if (gap_valid)
                        check(cyc == gap_cyc, "R6 request cycle", cyc, gap_cyc);
                    gap_valid = 1'b0;
                    if (q_idx.size() == 0) begin
                        check(1'b0, "R10 unexpected request after result", idx, -1);
                    end else begin
                        int ei;
                        logic [31:0] ea;
                        logic [7:0] ec;
                        ei = q_idx.pop_front();
                        ea = q_arg.pop_front();
                        ec = q_crc.pop_front();
                        check(idx == ei, {tag_of(ei), " index"}, idx, ei);
                        check(cmd_arg == ea, {tag_of(ei), " argument"}, cmd_arg, ea);
                        check(cmd_crc == ec, (ei == 0 || ei == 8) ? {tag_of(ei), " crc"} : "R10 crc",
                              cmd_crc, ec);
                    end
                    st = reply(idx);
                    to = (idx == s_to);
                    repeat (LAT) begin
                        @(negedge clk);
                        check(cmd_req == 1'b0, "R10 single-cycle request", cmd_req, 0);
                        check(cmd_index == h_idx && cmd_arg == h_arg && cmd_crc == h_crc,
                              "R10 fields held", cmd_arg, h_arg);
                    end
                    cmd_done = 1'b1;
                    cmd_status = st;
                    cmd_timeout = to;
                    if ((idx == 8 && st == 8'h01 && !to) ||
                        (idx == 41 && s_probe == 1 && (st != 8'h00 || to)))
                        gap_cyc = cyc + DLY + 2;
                    else
                        gap_cyc = cyc + 1;
                    gap_valid = 1'b1;
                    @(negedge clk);
                    cmd_done = 1'b0;
                    cmd_timeout = 1'b0;
                    cmd_status = 8'hFF;
                    skip = 1'b1;
                end
            end
        end
    end

    task automatic run_case(input string name, input int rst_v, input int probe_v,
                            input int fail41, input int blk_v, input int to_idx, input int ign_v);
        int waited;
        s_rst = rst_v; s_probe = probe_v; s_fail41 = fail41;
        s_blk = blk_v; s_to = to_idx; s_ign = ign_v;
        n41 = 0;
        n_bursts = 0;
        q_idx.delete(); q_arg.delete(); q_crc.delete();
        plan();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!(init_done || init_error) && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (12) @(negedge clk);
        $display("case %s", name);
        check(n_bursts == 1, "R1 one burst per run", n_bursts, 1);
        check(init_done == e_done, e_done ? "R7 done flag" : "R9 done flag low", init_done, e_done);
        check(init_error == !e_done, e_done ? "R7 error flag low" : "R9 error flag", init_error, !e_done);
        check(int'(card_type) == e_type, "R8 card type", card_type, e_type);
        check(int'(addr_mult) == e_mult, "R8 address multiplier", addr_mult, e_mult);
        check(clk_fast == e_done, "R7 clock select", clk_fast, e_done);
        check(q_idx.size() == 0, "R10 command stream complete", q_idx.size(), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_req && !dummy_req && !init_done && !init_error && !clk_fast &&
              card_type == 2'd0 && addr_mult == 10'd0, "R10 reset state idle",
              {cmd_req, dummy_req, init_done, init_error, clk_fast}, 0);
        //       name                 rst  probe fail41 blk  to  ign
        run_case("legacy_two_retries", 1,  5,    2,     0,  -1, 1);
        run_case("hc_one_retry",       1,  1,    1,     0,  -1, 5);
        run_case("hc_first_try",       1,  1,    0,     0,  -1, 0);
        run_case("reset_not_idle",     0,  1,    0,     0,  -1, 1);
        run_case("reset_extra_bit",    3,  1,    0,     0,  -1, 1);
        run_case("probe_bad",          1,  4,    0,     0,  -1, 1);
        run_case("legacy_exhaust",     1,  5,   -1,     0,  -1, 1);
        run_case("hc_exhaust",         1,  1,   -1,     0,  -1, 1);
        run_case("blklen_reject",      1,  5,    0,     4,  -1, 1);
        run_case("probe_timeout",      1,  1,    0,     0,   8, 1);
        run_case("opcond_timeout",     1,  5,    0,     0,  41, 1);
        run_case("app_timeout_ignored",1,  5,    1,     0,  55, 1);
        run_case("legacy_after_error", 1,  5,    0,     0,  -1, 1);
        finish_run();
    end

endmodule